// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block sits beside the command path of a DDR3-style memory controller or a memory model. On every rising clock edge it takes the clock-enable level sampled at that edge and the decoded command registered at that edge. It combines them with the clock-enable level from the edge before and with two status hints: all banks closed, and an operation still in flight. From these it follows the device through normal operation, active power-down, precharge power-down and self-refresh.

Each clock-enable or command sequence that the power-management rules forbid raises its own sticky flag. A flag stays set until reset, so a long run can be checked once at its end. When clock-enable is high on both edges, the command is left to normal command handling and is judged only inside the window that follows a self-refresh exit.

Top module: `cke_pwr_tracker`

## Requirements
- R1: Reset puts `pwr_state_o` at 00 (normal) and clears all six violation flags. The previous clock-enable level is taken as high, and the hold rule is taken as already met.
- R2: The state codes are 00 normal, 01 active power-down, 10 precharge power-down and 11 self-refresh. Command codes are 0 DESL, 1 NOP, 2 REFRESH and 3 READ; codes 4 to 7 are other commands. In normal state, a high-to-low clock-enable edge that carries DESL or NOP enters state 10 if `all_idle_i` is 1 and state 01 otherwise.
- R3: In normal state, a high-to-low edge that carries REFRESH with `all_idle_i`=1 and `busy_i`=0 enters state 11.
- R4: A high-to-low edge that carries REFRESH while `all_idle_i`=0 or `busy_i`=1 leaves the state at 00 and sets `viol_sre_o`.
- R5: In normal state, a high-to-low edge that carries any command other than DESL, NOP or REFRESH leaves the state at 00 and sets `viol_entry_o`.
- R6: In states 01, 10 and 11, an edge with clock-enable low keeps the state, whatever the command is.
- R7: In states 01, 10 and 11, a low-to-high edge always returns the state to 00. If the command on that edge is not DESL or NOP, `viol_exit_o` is also set.
- R8: When clock-enable is high on both edges in normal state, the state does not change and no flag is set, unless R10 or R11 applies.
- R9: After a clock-enable change, the new level must be sampled on at least TCKE consecutive edges, counting the edge of the change. A change that comes sooner sets `viol_hold_o`.
- R10: Call the self-refresh exit edge offset 0. On the edges at offsets 1 to TXS-1 where clock-enable is high on both edges, any command other than DESL or NOP sets `viol_xs_o`.
- R11: On the edges at offsets 1 to TXSDLL-1 where clock-enable is high on both edges, a READ sets `viol_read_o`. One edge can set both this flag and the R10 flag.
- R12: Clock-enable sampled low ends the post-exit window. A later exit from power-down does not open a new window.
- R13: Every violation flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock; all sampling on the rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| cke_i | input | 1 | Clock-enable level sampled at this edge |
| cmd_i | input | 3 | Decoded command: 0 DESL, 1 NOP, 2 REFRESH, 3 READ, 4-7 other |
| all_idle_i | input | 1 | All banks closed and all timings met |
| busy_i | input | 1 | Read, write, mode-register or precharge activity in progress |
| pwr_state_o | output | 2 | Power state: 00 normal, 01 active PD, 10 precharge PD, 11 self-refresh |
| viol_hold_o | output | 1 | Sticky: clock-enable level held for fewer than TCKE edges |
| viol_entry_o | output | 1 | Sticky: power-down entry with an illegal command |
| viol_sre_o | output | 1 | Sticky: self-refresh entry while not idle |
| viol_exit_o | output | 1 | Sticky: exit edge carried an illegal command |
| viol_xs_o | output | 1 | Sticky: non-DESL/NOP command inside the post-exit TXS window |
| viol_read_o | output | 1 | Sticky: READ before TXSDLL after self-refresh exit |

## Verification
Two pairs of functions can act on the same edge. The first pair is the TXS command rule and the TXSDLL read rule. A READ issued one edge after a self-refresh exit breaks both rules, and both `viol_xs_o` and `viol_read_o` must rise together. A READ issued after TXS but before TXSDLL must raise only the read flag. The second pair is the exit logic and the hold monitor. An exit one edge after power-down entry must return the state to normal and set `viol_hold_o` on that same edge. The bench model computes each flag on its own every clock, so a merged or dropped flag shows up as a mismatch.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    localparam logic [2:0] CMD_DESL    = 3'd0;
    localparam logic [2:0] CMD_NOP     = 3'd1;
    localparam logic [2:0] CMD_REFRESH = 3'd2;
    localparam logic [2:0] CMD_READ    = 3'd3;

    typedef enum logic [1:0] {
        PS_NORMAL   = 2'b00,
        PS_ACT_PD   = 2'b01,
        PS_PRE_PD   = 2'b10,
        PS_SELF_REF = 2'b11
    } pstate_e;

    typedef struct packed {
        logic hold;
        logic entry;
        logic sre;
        logic exit_cmd;
        logic xs_cmd;
        logic xs_read;
    } viol_t;

    function automatic logic is_quiet(input logic [2:0] cmd);
        return (cmd == CMD_DESL) || (cmd == CMD_NOP);
    endfunction

endpackage

// File: rtl/cke_hold_mon.sv
module cke_hold_mon
    import cke_pwr_pkg::*;
#(
    parameter int unsigned TCKE = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cke_i,
    output logic cke_prev_o,
    output logic hold_bad_o
);

    localparam int unsigned RUN_W = $clog2(TCKE + 1);
    localparam logic [RUN_W-1:0] RUN_MIN = RUN_W'(TCKE);

    typedef struct packed {
        logic             prev;
        logic [RUN_W-1:0] run;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        hold_bad_o = 1'b0;
        if (cke_i != st_q.prev) begin
            hold_bad_o = (st_q.run < RUN_MIN);
            st_d.run   = RUN_W'(1);
        end else if (st_q.run < RUN_MIN) begin
            st_d.run = st_q.run + 1'b1;
        end
        st_d.prev = cke_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{prev: 1'b1, run: RUN_MIN};
        end else begin
            st_q <= st_d;
        end
    end

    assign cke_prev_o = st_q.prev;

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
    import cke_pwr_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cke_prev_i,
    input  logic       cke_i,
    input  logic [2:0] cmd_i,
    input  logic       all_idle_i,
    input  logic       busy_i,
    output pstate_e    state_o,
    output logic       sr_exit_o,
    output logic       exit_bad_o,
    output logic       entry_bad_o,
    output logic       sre_bad_o
);

    typedef struct packed {
        pstate_e ps;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    quiet;

    always_comb begin
        quiet       = is_quiet(cmd_i);
        st_d        = st_q;
        sr_exit_o   = 1'b0;
        exit_bad_o  = 1'b0;
        entry_bad_o = 1'b0;
        sre_bad_o   = 1'b0;
        unique case (st_q.ps)
            PS_NORMAL: begin
                if (cke_prev_i && !cke_i) begin
                    if (quiet) begin
                        st_d.ps = all_idle_i ? PS_PRE_PD : PS_ACT_PD;
                    end else if (cmd_i == CMD_REFRESH) begin
                        if (all_idle_i && !busy_i) begin
                            st_d.ps = PS_SELF_REF;
                        end else begin
                            sre_bad_o = 1'b1;
                        end
                    end else begin
                        entry_bad_o = 1'b1;
                    end
                end
            end
            default: begin
                if (cke_i) begin
                    st_d.ps    = PS_NORMAL;
                    exit_bad_o = !quiet;
                    sr_exit_o  = (st_q.ps == PS_SELF_REF);
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{ps: PS_NORMAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.ps;

endmodule

// File: rtl/srx_window_mon.sv
module srx_window_mon
    import cke_pwr_pkg::*;
#(
    parameter int unsigned TXS    = 5,
    parameter int unsigned TXSDLL = 512
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sr_exit_i,
    input  logic       cke_prev_i,
    input  logic       cke_i,
    input  logic [2:0] cmd_i,
    output logic       xs_bad_o,
    output logic       read_bad_o
);

    localparam int unsigned OFS_W = $clog2(TXSDLL + 1);
    localparam logic [OFS_W-1:0] OFS_XS  = OFS_W'(TXS);
    localparam logic [OFS_W-1:0] OFS_DLL = OFS_W'(TXSDLL);

    typedef struct packed {
        logic             active;
        logic [OFS_W-1:0] ofs;
    } win_st_t;

    win_st_t          st_d, st_q;
    logic             judged;
    logic [OFS_W-1:0] ofs_nxt;

    always_comb begin
        st_d       = st_q;
        judged     = st_q.active && cke_prev_i && cke_i;
        xs_bad_o   = judged && (st_q.ofs < OFS_XS) && !is_quiet(cmd_i);
        read_bad_o = judged && (st_q.ofs < OFS_DLL) && (cmd_i == CMD_READ);
        ofs_nxt    = st_q.ofs + 1'b1;
        if (sr_exit_i) begin
            st_d.active = 1'b1;
            st_d.ofs    = OFS_W'(1);
        end else if (st_q.active) begin
            if (!cke_i) begin
                st_d.active = 1'b0;
            end else begin
                st_d.ofs = ofs_nxt;
                if (ofs_nxt >= OFS_DLL) begin
                    st_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{active: 1'b0, ofs: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cke_pwr_tracker.sv
module cke_pwr_tracker
    import cke_pwr_pkg::*;
#(
    parameter int unsigned TCKE   = 3,
    parameter int unsigned TXS    = 5,
    parameter int unsigned TXSDLL = 512
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cke_i,
    input  logic [2:0] cmd_i,
    input  logic       all_idle_i,
    input  logic       busy_i,
    output logic [1:0] pwr_state_o,
    output logic       viol_hold_o,
    output logic       viol_entry_o,
    output logic       viol_sre_o,
    output logic       viol_exit_o,
    output logic       viol_xs_o,
    output logic       viol_read_o
);

    logic    cke_prev;
    logic    sr_exit;
    pstate_e state;
    viol_t   hits;
    viol_t   flags_d, flags_q;

    cke_hold_mon #(.TCKE(TCKE)) i_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cke_i      (cke_i),
        .cke_prev_o (cke_prev),
        .hold_bad_o (hits.hold)
    );

    pwr_state_fsm i_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cke_prev_i  (cke_prev),
        .cke_i       (cke_i),
        .cmd_i       (cmd_i),
        .all_idle_i  (all_idle_i),
        .busy_i      (busy_i),
        .state_o     (state),
        .sr_exit_o   (sr_exit),
        .exit_bad_o  (hits.exit_cmd),
        .entry_bad_o (hits.entry),
        .sre_bad_o   (hits.sre)
    );

    srx_window_mon #(.TXS(TXS), .TXSDLL(TXSDLL)) i_win (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sr_exit_i  (sr_exit),
        .cke_prev_i (cke_prev),
        .cke_i      (cke_i),
        .cmd_i      (cmd_i),
        .xs_bad_o   (hits.xs_cmd),
        .read_bad_o (hits.xs_read)
    );

    always_comb begin
        flags_d = flags_q | hits;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign pwr_state_o  = state;
    assign viol_hold_o  = flags_q.hold;
    assign viol_entry_o = flags_q.entry;
    assign viol_sre_o   = flags_q.sre;
    assign viol_exit_o  = flags_q.exit_cmd;
    assign viol_xs_o    = flags_q.xs_cmd;
    assign viol_read_o  = flags_q.xs_read;

endmodule

// File: rtl/cke_pwr_checker.sv
module cke_pwr_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cke_i,
    input logic [2:0] cmd_i,
    input logic       all_idle_i,
    input logic       busy_i,
    input logic [1:0] pwr_state_o,
    input logic       viol_hold_o,
    input logic       viol_entry_o,
    input logic       viol_sre_o,
    input logic       viol_exit_o,
    input logic       viol_xs_o,
    input logic       viol_read_o
);

    AST_SR_ONLY_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o == 2'b00 && !cke_i && cmd_i == 3'd2 && !(all_idle_i && !busy_i))
        |=> (pwr_state_o == 2'b00)); // R4

    AST_LOW_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o != 2'b00 && !cke_i) |=> $stable(pwr_state_o)); // R6

    AST_HIGH_EXITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o != 2'b00 && cke_i) |=> (pwr_state_o == 2'b00)); // R7

    AST_BAD_EXIT_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o != 2'b00 && cke_i && cmd_i > 3'd1) |=> viol_exit_o); // R7

    AST_HIGH_STAYS_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o == 2'b00 && cke_i) |=> (pwr_state_o == 2'b00)); // R8

    AST_HOLD_STICKY:  assert property (@(posedge clk_i) disable iff (!rst_ni) viol_hold_o  |=> viol_hold_o);  // R13
    AST_ENTRY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) viol_entry_o |=> viol_entry_o); // R13
    AST_SRE_STICKY:   assert property (@(posedge clk_i) disable iff (!rst_ni) viol_sre_o   |=> viol_sre_o);   // R13
    AST_EXIT_STICKY:  assert property (@(posedge clk_i) disable iff (!rst_ni) viol_exit_o  |=> viol_exit_o);  // R13
    AST_XS_STICKY:    assert property (@(posedge clk_i) disable iff (!rst_ni) viol_xs_o    |=> viol_xs_o);    // R13
    AST_READ_STICKY:  assert property (@(posedge clk_i) disable iff (!rst_ni) viol_read_o  |=> viol_read_o);  // R13

endmodule

bind cke_pwr_tracker cke_pwr_checker i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cke_i        (cke_i),
    .cmd_i        (cmd_i),
    .all_idle_i   (all_idle_i),
    .busy_i       (busy_i),
    .pwr_state_o  (pwr_state_o),
    .viol_hold_o  (viol_hold_o),
    .viol_entry_o (viol_entry_o),
    .viol_sre_o   (viol_sre_o),
    .viol_exit_o  (viol_exit_o),
    .viol_xs_o    (viol_xs_o),
    .viol_read_o  (viol_read_o)
);

// File: tb/test_cke_pwr_tracker.sv
module test_cke_pwr_tracker;

    localparam int TCKE   = 3;
    localparam int TXS    = 5;
    localparam int TXSDLL = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic [2:0] cmd = 3'd1;
    logic       idle = 1'b1;
    logic       busy = 1'b0;
    logic [1:0] pwr_state;
    logic       v_hold, v_entry, v_sre, v_exit, v_xs, v_read;

    always #4 clk = ~clk;

    cke_pwr_tracker #(.TCKE(TCKE), .TXS(TXS), .TXSDLL(TXSDLL)) i_cke_pwr_tracker (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cke_i        (cke),
        .cmd_i        (cmd),
        .all_idle_i   (idle),
        .busy_i       (busy),
        .pwr_state_o  (pwr_state),
        .viol_hold_o  (v_hold),
        .viol_entry_o (v_entry),
        .viol_sre_o   (v_sre),
        .viol_exit_o  (v_exit),
        .viol_xs_o    (v_xs),
        .viol_read_o  (v_read)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    // behavioural reference model
    int m_state;
    bit m_prev;
    int m_run;
    bit m_win;
    int m_ofs;
    bit f_hold, f_entry, f_sre, f_exit, f_xs, f_read;

    always @(posedge clk) begin
        bit q;
        bit sr_ex;
        if (!rst_n) begin
            m_state = 0; m_prev = 1'b1; m_run = TCKE; m_win = 1'b0; m_ofs = 0;
            {f_hold, f_entry, f_sre, f_exit, f_xs, f_read} = '0;
        end else begin
            q = (cmd == 3'd0) || (cmd == 3'd1);
            sr_ex = 1'b0;
            if (cke != m_prev) begin
                if (m_run < TCKE) f_hold = 1'b1;
                m_run = 1;
            end else if (m_run < TCKE) begin
                m_run++;
            end
            if (m_win && m_prev && cke) begin
                if (m_ofs < TXS && !q) f_xs = 1'b1;
                if (m_ofs < TXSDLL && cmd == 3'd3) f_read = 1'b1;
            end
            if (m_state == 0) begin
                if (m_prev && !cke) begin
                    if (q) m_state = idle ? 2 : 1;
                    else if (cmd == 3'd2) begin
                        if (idle && !busy) m_state = 3;
                        else f_sre = 1'b1;
                    end else f_entry = 1'b1;
                end
            end else if (cke) begin
                if (!q) f_exit = 1'b1;
                if (m_state == 3) sr_ex = 1'b1;
                m_state = 0;
            end
            if (sr_ex) begin
                m_win = 1'b1; m_ofs = 1;
            end else if (m_win) begin
                if (!cke) m_win = 1'b0;
                else begin
                    m_ofs++;
                    if (m_ofs >= TXSDLL) m_win = 1'b0;
                end
            end
            m_prev = cke;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("state", int'(pwr_state), m_state);
            chk("viol_hold", int'(v_hold), int'(f_hold));
            chk("viol_entry", int'(v_entry), int'(f_entry));
            chk("viol_sre", int'(v_sre), int'(f_sre));
            chk("viol_exit", int'(v_exit), int'(f_exit));
            chk("viol_xs", int'(v_xs), int'(f_xs));
            chk("viol_read", int'(v_read), int'(f_read));
        end
    end

    task automatic drive(input bit c, input int cm, input bit id, input bit bs);
        @(negedge clk);
        cke = c; cmd = 3'(cm); idle = id; busy = bs;
    endtask

    task automatic hold_n(input int n, input bit c, input int cm);
        for (int i = 0; i < n; i++) drive(c, cm, idle, busy);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cke = 1'b1; cmd = 3'd1; idle = 1'b1; busy = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        phase = "R1";
        do_reset();
        hold_n(2, 1'b1, 1);

        phase = "R8";
        for (int i = 0; i < 8; i++) drive(1'b1, i, 1'b0, i[0]);

        phase = "R2";
        drive(1'b0, 1, 1'b0, 1'b1);          // active power-down
        phase = "R6";
        drive(1'b0, 2, 1'b0, 1'b1);
        drive(1'b0, 3, 1'b1, 1'b0);
        drive(1'b0, 6, 1'b0, 1'b0);
        phase = "R7";
        drive(1'b1, 0, 1'b1, 1'b0);
        hold_n(3, 1'b1, 1);
        phase = "R2";
        drive(1'b0, 0, 1'b1, 1'b0);          // precharge power-down
        hold_n(3, 1'b0, 5);
        drive(1'b1, 1, 1'b1, 1'b0);
        hold_n(3, 1'b1, 1);

        phase = "R3";
        drive(1'b0, 2, 1'b1, 1'b0);          // self-refresh
        hold_n(4, 1'b0, 7);
        phase = "R10";
        drive(1'b1, 1, 1'b1, 1'b0);          // exit, offset 0
        drive(1'b1, 1, 1'b1, 1'b0);          // offset 1
        drive(1'b1, 7, 1'b1, 1'b0);          // offset 2 -> xs
        hold_n(4, 1'b1, 1);

        phase = "R11";                       // same-edge xs + read
        do_reset();
        drive(1'b0, 2, 1'b1, 1'b0);
        hold_n(3, 1'b0, 0);
        drive(1'b1, 0, 1'b1, 1'b0);
        drive(1'b1, 3, 1'b1, 1'b0);          // offset 1 READ
        hold_n(3, 1'b1, 1);

        phase = "R11";                       // read after TXS, before TXSDLL
        do_reset();
        drive(1'b0, 2, 1'b1, 1'b0);
        hold_n(3, 1'b0, 0);
        drive(1'b1, 1, 1'b1, 1'b0);
        hold_n(TXS - 1, 1'b1, 1);
        drive(1'b1, 6, 1'b1, 1'b0);          // offset TXS, allowed
        drive(1'b1, 3, 1'b1, 1'b0);          // offset TXS+1 READ
        hold_n(3, 1'b1, 1);

        phase = "R11";                       // read exactly at TXSDLL
        do_reset();
        drive(1'b0, 2, 1'b1, 1'b0);
        hold_n(3, 1'b0, 0);
        drive(1'b1, 1, 1'b1, 1'b0);
        hold_n(TXSDLL - 1, 1'b1, 0);
        drive(1'b1, 3, 1'b1, 1'b0);
        hold_n(3, 1'b1, 1);

        phase = "R12";
        do_reset();
        drive(1'b0, 2, 1'b1, 1'b0);
        hold_n(3, 1'b0, 0);
        drive(1'b1, 1, 1'b1, 1'b0);
        hold_n(2, 1'b1, 1);
        drive(1'b0, 1, 1'b1, 1'b0);          // back to power-down
        hold_n(3, 1'b0, 1);
        drive(1'b1, 1, 1'b1, 1'b0);
        drive(1'b1, 3, 1'b1, 1'b0);          // READ, no window
        hold_n(3, 1'b1, 4);

        phase = "R4";
        do_reset();
        drive(1'b0, 2, 1'b1, 1'b1);
        hold_n(3, 1'b0, 1);
        drive(1'b1, 1, 1'b1, 1'b0);
        hold_n(3, 1'b1, 1);
        drive(1'b0, 2, 1'b0, 1'b0);
        hold_n(3, 1'b0, 1);
        drive(1'b1, 1, 1'b1, 1'b0);
        hold_n(3, 1'b1, 1);

        phase = "R5";
        do_reset();
        drive(1'b0, 5, 1'b1, 1'b0);
        hold_n(3, 1'b0, 1);
        drive(1'b1, 1, 1'b1, 1'b0);
        hold_n(3, 1'b1, 1);

        phase = "R9";
        do_reset();
        drive(1'b0, 1, 1'b1, 1'b0);
        drive(1'b1, 1, 1'b1, 1'b0);          // exit too early
        hold_n(3, 1'b1, 1);
        drive(1'b0, 1, 1'b0, 1'b0);
        hold_n(2, 1'b0, 1);
        drive(1'b1, 1, 1'b0, 1'b0);          // exactly TCKE, legal
        hold_n(3, 1'b1, 1);

        phase = "R7";
        do_reset();
        drive(1'b0, 0, 1'b0, 1'b0);
        hold_n(3, 1'b0, 0);
        drive(1'b1, 6, 1'b0, 1'b0);
        hold_n(3, 1'b1, 1);

        phase = "R13";
        for (int i = 0; i < 400; i++) begin
            drive(($urandom % 5) != 0 ? cke : ~cke, int'($urandom % 8),
                  1'($urandom), 1'(($urandom % 4) == 0));
        end
        hold_n(4, 1'b1, 1);

        finish_run();
    end

endmodule